// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a memory-mapped watchdog for a processor subsystem. Software writes a tick count into the timer register. That count passes through a short load pipeline and then becomes the live value of a 32-bit down-counter. Software writes the timer again before the count runs out; this is the keepalive. If the counter reaches zero, a two-bit action field in the control register decides the result. The choices are no effect, a held general-purpose interrupt, a held non-maskable interrupt, or a one-cycle request to the system reset controller.

The block has two reset inputs. The system reset returns the block to its idle state. The power-on reset also clears a sticky "last reset came from the watchdog" flag. That flag is set when the block requests a chip reset. Because the system reset does not clear it, software can read it after the chip comes back up. The bus has one clock of write strobe and a combinational read.

Top module: `wdog_action_timer`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0, the timer register (offset 0x04) reads 0, and irq, nmi and rst_req are low.
- R2: A timer write reaches the counter exactly two clock edges after the edge that samples the write. Before that, the old count is still visible. A control write issued after that delay operates on the new count.
- R3: While nonzero, the counter decreases by one on every clock. It holds at zero. Reading the timer register returns the live count over the full 32-bit range.
- R4: Control bits [1:0] hold the action: 0 = none, 1 = interrupt, 2 = NMI, 3 = chip reset. Bits [30:2] read as zero and ignore writes. Bit 31 is the watchdog-reset flag, and writes do not change it.
- R5: Expiry is the counter stepping from 1 to 0. With action 1, irq rises in the cycle the count first reads zero. It stays high until a later timer load takes effect. nmi and rst_req stay low.
- R6: With action 2, nmi behaves the way irq does in R5, and irq and rst_req stay low.
- R7: With action 3, rst_req is high for exactly one cycle, in the cycle the count first reads zero.
- R8: Control bit 31 sets in the same cycle as the rst_req pulse. It survives the system reset and is cleared only by the power-on reset.
- R9: With action 0, an expiry drives none of irq, nmi or rst_req.
- R10: A timer reload that takes effect before the count reaches zero restarts the countdown and prevents the expiry.
- R11: Addresses other than 0x00 and 0x04 read as zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock; one tick per edge |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| por_n | input | 1 | Active-low power-on reset; also clears the flag |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Held interrupt on expiry with action 1 |
| nmi | output | 1 | Held NMI on expiry with action 2 |
| rst_req | output | 1 | One-cycle chip reset request on expiry with action 3 |

## Verification
The assertions check, on every cycle, the rules that hold from one edge to the next. These are: a committed load sets the count, each cycle decrements or holds it, irq and nmi are held, the reset request lasts one cycle, and at most one output is high at a time. They also check that the flag is present whenever a reset request is, that it stays sticky, and that reserved read bits are zero. Only the bench scenarios can show the absolute timing. That includes how many cycles a write takes to reach the counter, the cycle an output rises for a given load, and the full-width count. It also includes the way the two resets act differently on the flag, and the absence of any effect from unmapped and reserved writes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_IRQ     = 2'd1,
    ACT_NMI     = 2'd2,
    ACT_CHIPRST = 2'd3
  } wdog_act_e;

  localparam int unsigned ACT_W     = 2;
  localparam int unsigned FLAG_BIT  = 31;

  typedef struct packed {
    logic      flag;
    wdog_act_e action;
  } wdog_ctrl_t;

  // Register word as seen on the bus for the control offset
  function automatic logic [31:0] ctrl_word(input wdog_ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[FLAG_BIT]    = c.flag;
    w[ACT_W-1:0]   = c.action;
    return w;
  endfunction

endpackage

// File: rtl/wdog_load_sync.sv
module wdog_load_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_data
);

  logic             vld_q  [STAGES];
  logic [WIDTH-1:0] data_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[g]  <= 1'b0;
            data_q[g] <= '0;
          end else begin
            vld_q[g]  <= in_vld;
            if (in_vld) data_q[g] <= in_data;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[g]  <= 1'b0;
            data_q[g] <= '0;
          end else begin
            vld_q[g]  <= vld_q[g-1];
            if (vld_q[g-1]) data_q[g] <= data_q[g-1];
          end
        end
      end
    end
  endgenerate

  assign out_vld  = vld_q[STAGES-1];
  assign out_data = data_q[STAGES-1];

endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             expire
);

  function automatic logic [WIDTH-1:0] step(
    input logic [WIDTH-1:0] cur,
    input logic             ld,
    input logic [WIDTH-1:0] val
  );
    if (ld)              return val;
    else if (cur != '0)  return cur - WIDTH'(1);
    else                 return cur;
  endfunction

  function automatic logic hits_zero(input logic [WIDTH-1:0] cur, input logic ld);
    return !ld && (cur == WIDTH'(1));
  endfunction

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= step(cnt_q, load, load_val);
  end

  assign count  = cnt_q;
  assign expire = hits_zero(cnt_q, load);

endmodule

// File: rtl/wdog_action_out.sv
module wdog_action_out
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wdog_act_e action,
  input  logic      expire,
  input  logic      reload,
  output logic      irq,
  output logic      nmi,
  output logic      rst_req,
  output logic      set_flag
);

  logic irq_q, nmi_q, rst_q;
  logic fire_irq, fire_nmi, fire_rst;

  assign fire_irq = expire && (action == ACT_IRQ);
  assign fire_nmi = expire && (action == ACT_NMI);
  assign fire_rst = expire && (action == ACT_CHIPRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (reload)        irq_q <= 1'b0;
      else if (fire_irq) irq_q <= 1'b1;
      if (reload)        nmi_q <= 1'b0;
      else if (fire_nmi) nmi_q <= 1'b1;
      rst_q <= fire_rst;
    end
  end

  assign irq      = irq_q;
  assign nmi      = nmi_q;
  assign rst_req  = rst_q;
  assign set_flag = fire_rst;

endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_flag,
  output wdog_ctrl_t        ctrl
);

  wdog_act_e act_q;
  logic      flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= ACT_NONE;
    else if (wr_ctrl) act_q <= wdog_act_e'(wdata[ACT_W-1:0]);
  end

  // Sticky flag: only the power-on reset clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        flag_q <= 1'b0;
    else if (set_flag) flag_q <= 1'b1;
  end

  assign ctrl.action = act_q;
  assign ctrl.flag   = flag_q;

endmodule

// File: rtl/wdog_action_timer.sv
module wdog_action_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 4'h0,
  parameter logic [ADDR_W-1:0] TIMER_OFS = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              nmi,
  output logic              rst_req
);

  localparam int unsigned CNT_W = DATA_W;

  logic              sys_rst_n;
  logic              ctrl_sel, timer_sel;
  logic              load_commit;
  logic [CNT_W-1:0]  load_value;
  logic [CNT_W-1:0]  tick_cnt;
  logic              expire_evt;
  logic              flag_set;
  wdog_ctrl_t        ctrl_q;

  assign sys_rst_n = rst_n & por_n;
  assign ctrl_sel  = (bus_addr == CTRL_OFS);
  assign timer_sel = (bus_addr == TIMER_OFS);

  wdog_load_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .in_vld   (bus_wr && timer_sel),
    .in_data  (bus_wdata),
    .out_vld  (load_commit),
    .out_data (load_value)
  );

  wdog_down_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .load     (load_commit),
    .load_val (load_value),
    .count    (tick_cnt),
    .expire   (expire_evt)
  );

  wdog_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .por_n    (por_n),
    .wr_ctrl  (bus_wr && ctrl_sel),
    .wdata    (bus_wdata),
    .set_flag (flag_set),
    .ctrl     (ctrl_q)
  );

  wdog_action_out u_act (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .action   (ctrl_q.action),
    .expire   (expire_evt),
    .reload   (load_commit),
    .irq      (irq),
    .nmi      (nmi),
    .rst_req  (rst_req),
    .set_flag (flag_set)
  );

  always_comb begin
    if (ctrl_sel)       bus_rdata = DATA_W'(ctrl_word(ctrl_q));
    else if (timer_sel) bus_rdata = DATA_W'(tick_cnt);
    else                bus_rdata = '0;
  end

endmodule

// File: rtl/wdog_action_timer_chk.sv
module wdog_action_timer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              sys_rst_n,
  input logic              por_n,
  input logic              ctrl_sel,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              nmi,
  input logic              rst_req,
  input logic              load_commit,
  input logic [DATA_W-1:0] load_value,
  input logic [DATA_W-1:0] tick_cnt,
  input logic              expire_evt,
  input logic [1:0]        action,
  input logic              flag
);

  // R2: a committed load is the next count
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    load_commit |=> (tick_cnt == $past(load_value)));

  // R3: one step down per clock while nonzero
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!load_commit && tick_cnt != '0) |=> (tick_cnt == $past(tick_cnt) - 1));

  // R3: holds at zero without a load
  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!load_commit && tick_cnt == '0) |=> (tick_cnt == '0));

  // R4: reserved control bits read as zero
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ctrl_sel |-> (bus_rdata[DATA_W-2:2] == '0));

  // R5: interrupt held until a load commits
  assert_irq_held_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (irq && !load_commit) |=> irq);

  // R6: NMI held until a load commits
  assert_nmi_held_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (nmi && !load_commit) |=> nmi);

  // R5: at most one expiry output active
  assert_one_output_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $onehot0({irq, nmi, rst_req}));

  // R7: reset request lasts one cycle
  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_req |=> !rst_req);

  // R8: the flag accompanies a reset request
  assert_flag_with_req_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_req |-> flag);

  // R8: flag is sticky until power-on reset
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    flag |=> flag);

  // R9: no output from an expiry with action none
  assert_silent_off_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (expire_evt && action == 2'd0) |=> (!rst_req && $stable(irq) && $stable(nmi)));

endmodule

bind wdog_action_timer wdog_action_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .sys_rst_n   (sys_rst_n),
  .por_n       (por_n),
  .ctrl_sel    (ctrl_sel),
  .bus_rdata   (bus_rdata),
  .irq         (irq),
  .nmi         (nmi),
  .rst_req     (rst_req),
  .load_commit (load_commit),
  .load_value  (load_value),
  .tick_cnt    (tick_cnt),
  .expire_evt  (expire_evt),
  .action      (ctrl_q.action),
  .flag        (ctrl_q.flag)
);

// File: tb/wdog_action_timer_bench.sv
module wdog_action_timer_bench;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_TIMER = 4'h4;

  logic        clk = 1'b0;
  logic        rst_n, por_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, nmi, rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_action_timer u_wdog_action_timer (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .nmi(nmi), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic outs(input string req, input logic [2:0] exp);
    chk(req, {29'd0, irq, nmi, rst_req}, {29'd0, exp});
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    cycles(2); rst_n = 1'b1;
    @(negedge clk);
  endtask

  // load W and wait until it is visible (two edges after the write edge)
  task automatic load_visible(input string req, input logic [31:0] w);
    logic [31:0] d;
    wr(A_TIMER, w);
    cycles(2);
    rd(A_TIMER, d);
    chk(req, d, w);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
    rd(A_TIMER, d); chk("R1 timer", d, 32'h0);
    outs("R1 outputs", 3'b000);
  endtask

  task automatic t_load_delay();
    logic [31:0] d;
    wr(A_TIMER, 32'd100);
    rd(A_TIMER, d); chk("R2 not yet after write edge", d, 32'd0);
    @(negedge clk);
    rd(A_TIMER, d); chk("R2 not yet after one edge", d, 32'd0);
    @(negedge clk);
    rd(A_TIMER, d); chk("R2 loaded after two edges", d, 32'd100);
    wr(A_CTRL, 32'd1);
    rd(A_TIMER, d); chk("R2 enable sees new count", d, 32'd99);
    cycles(9);
    rd(A_TIMER, d); chk("R3 decrement", d, 32'd90);
    sys_reset();
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, d); chk("R4 reserved and flag bits ignore writes", d, 32'h0000_0002);
    wr(A_CTRL, 32'h7FFF_FFFD);
    rd(A_CTRL, d); chk("R4 action field", d, 32'h0000_0001);
    sys_reset();
  endtask

  task automatic t_held(input string req, input logic [1:0] act, input logic [2:0] pat);
    logic [31:0] d;
    wr(A_CTRL, {30'd0, act});
    load_visible(req, 32'd5);
    cycles(4);
    rd(A_TIMER, d); chk(req, d, 32'd1);
    outs(req, 3'b000);
    @(negedge clk);
    rd(A_TIMER, d); chk(req, d, 32'd0);
    outs(req, pat);
    cycles(6);
    outs(req, pat);
    wr(A_TIMER, 32'd50);
    outs(req, pat);
    cycles(2);
    outs(req, 3'b000);
    sys_reset();
  endtask

  task automatic t_chip_reset();
    logic [31:0] d;
    int highs;
    wr(A_CTRL, 32'd3);
    load_visible("R7 load", 32'd3);
    cycles(2);
    outs("R7 before expiry", 3'b000);
    highs = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) outs("R7 pulse on zero", 3'b001);
      if (rst_req) highs++;
    end
    chk("R7 one-cycle pulse", highs, 1);
    rd(A_CTRL, d); chk("R8 flag set", d, 32'h8000_0003);
    sys_reset();
    rd(A_CTRL, d); chk("R8 flag survives system reset", d, 32'h8000_0000);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); chk("R8 flag ignores writes", d, 32'h8000_0000);
    @(negedge clk); por_n = 1'b0;
    cycles(2); por_n = 1'b1;
    @(negedge clk);
    rd(A_CTRL, d); chk("R8 power-on clears flag", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(A_CTRL, 32'd2);
    load_visible("R9 load", 32'd6);
    wr(A_CTRL, 32'd0);
    cycles(8);
    rd(A_TIMER, d); chk("R9 counter expired", d, 32'd0);
    outs("R9 no output", 3'b000);
    rd(A_CTRL, d); chk("R9 no flag", d, 32'd0);
    sys_reset();
  endtask

  task automatic t_keepalive();
    logic [31:0] d;
    bit seen;
    wr(A_CTRL, 32'd1);
    load_visible("R10 load", 32'd10);
    cycles(6);
    wr(A_TIMER, 32'd10);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    chk("R10 no expiry", {31'd0, seen}, 32'd0);
    rd(A_TIMER, d); chk("R10 restarted count", d, 32'd4);
    sys_reset();
  endtask

  task automatic t_full_range();
    logic [31:0] d;
    load_visible("R3 full width", 32'hFFFF_FFFF);
    @(negedge clk);
    rd(A_TIMER, d); chk("R3 full width step", d, 32'hFFFF_FFFE);
    sys_reset();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(4'h8, 32'h0000_0003);
    wr(4'hC, 32'h0000_0040);
    cycles(3);
    rd(4'h8, d);    chk("R11 read zero", d, 32'h0);
    rd(4'hC, d);    chk("R11 read zero high", d, 32'h0);
    rd(A_CTRL, d);  chk("R11 ctrl untouched", d, 32'h0);
    rd(A_TIMER, d); chk("R11 timer untouched", d, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    cycles(3);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_delay();
    t_reserved();
    t_held("R5 irq", 2'd1, 3'b100);
    t_held("R6 nmi", 2'd2, 3'b010);
    t_chip_reset();
    t_disabled();
    t_keepalive();
    t_full_range();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule